// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

This block watches a bank of general-purpose input pins and turns activity on them into one interrupt request. Every pin has its own trigger setup. It can fire on an edge or on a level. A polarity bit picks rising/high or falling/low. A separate bit makes an edge-mode pin fire on both edges.

Each pin first passes through a two-stage synchroniser. A detected condition sets a sticky per-pin status bit. Software clears that bit by writing 1 to its position. The clear takes effect only when the pin's condition is absent in that same cycle, so a level source that is still active keeps its bit set.

A per-pin mask gates only the path from status to the interrupt output. Detection and status keep running while a pin is masked. An event that arrives under mask is therefore held and shows up on the output as soon as the mask is lifted.

The register port is a plain synchronous write strobe with a combinational read of the addressed register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the registers read as follows: mask all 1s (1 = masked), mode 0 (level), polarity all 1s (high/rising), both-edge 0, and status 0. The interrupt output is low.
- R2: The register offsets are 0x00 mask, 0x04 mode (1 = edge), 0x08 polarity (1 = rising or high), 0x0C both-edge, and 0x10 status. Configuration registers read back what was written. Any other offset reads 0.
- R3: In edge mode with polarity 1 and both-edge 0, a rising input sets the pin's status bit. The bit is readable after the third rising clock edge that follows the input change. A falling input does not set it.
- R4: In edge mode with polarity 0 and both-edge 0, a falling input sets status and a rising input does not.
- R5: In edge mode with both-edge 1, either edge sets status, whatever the polarity.
- R6: In level mode, status is set while the synchronised input equals the polarity bit (1 = high, 0 = low).
- R7: Writing 1 to a status bit clears it when the pin's condition is absent in that cycle. Writing 0 to a status bit leaves it unchanged.
- R8: Writing 1 to a status bit whose level condition is still present leaves the bit at 1.
- R9: If a detected edge and a write-1 clear hit the same pin in the same cycle, the bit ends at 1.
- R10: While a pin is masked, its status still sets but does not drive the interrupt output. After the mask bit is cleared, the interrupt output rises on the following clock edge.
- R11: The interrupt output is a register. One cycle after any change, it equals the OR over all pins of status AND NOT mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPIN | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | NPIN | Write data; for status, 1 bits request a clear |
| rdata | output | NPIN | Contents of the addressed register |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the inputs are valid from the first clock after reset. They also assume that pin_in may change at any time, because it only ever reaches logic through the synchroniser. The properties about status rising and falling are written against the detected condition and the write-1 vector as they stood one cycle earlier. They do not depend on any ordering of software writes.

The bench changes pins and drives writes only on falling clock edges. It holds each pin steady long enough for the three-stage path to settle before it reads back. It also aligns the same-cycle clear exactly with the cycle in which the edge is seen.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic            irq
);
  localparam logic [AW-1:0] OFS_MASK = AW'(5'h00);
  localparam logic [AW-1:0] OFS_MODE = AW'(5'h04);
  localparam logic [AW-1:0] OFS_POL  = AW'(5'h08);
  localparam logic [AW-1:0] OFS_BOTH = AW'(5'h0C);
  localparam logic [AW-1:0] OFS_STAT = AW'(5'h10);
  localparam logic [NPIN-1:0] ONES   = {NPIN{1'b1}};
  localparam logic [NPIN-1:0] ZEROS  = {NPIN{1'b0}};

  logic [NPIN-1:0] meta_q, sync_q, last_q;
  logic [NPIN-1:0] mask_q, mode_q, pol_q, both_q, stat_q;
  logic [NPIN-1:0] rise, fall, edge_hit, lvl_hit, cond, clr;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= ZEROS;
      sync_q <= ZEROS;
      last_q <= ZEROS;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise     = sync_q & ~last_q;
  assign fall     = ~sync_q & last_q;
  assign edge_hit = (both_q & (rise | fall)) |
                    (~both_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = ~(sync_q ^ pol_q);
  assign cond     = (mode_q & edge_hit) | (~mode_q & lvl_hit);
  assign clr      = (wr_en && addr == OFS_STAT) ? wdata : ZEROS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= ONES;
      mode_q <= ZEROS;
      pol_q  <= ONES;
      both_q <= ZEROS;
    end else if (wr_en) begin
      case (addr)
        OFS_MASK: mask_q <= wdata;
        OFS_MODE: mode_q <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_BOTH: both_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= ZEROS;
    else        stat_q <= cond | (stat_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & ~mask_q);
  end

  assign irq = irq_q;

  always_comb begin
    case (addr)
      OFS_MASK: rdata = mask_q;
      OFS_MODE: rdata = mode_q;
      OFS_POL:  rdata = pol_q;
      OFS_BOTH: rdata = both_q;
      OFS_STAT: rdata = stat_q;
      default:  rdata = ZEROS;
    endcase
  end

  // R6 R8 R9: a detected condition always leaves its status bit set
  p_cond_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(cond)) == $past(cond)));

  // R7: a bit only falls after a write-1 to it
  p_fall_needs_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr)) == ZEROS));

  // R10: nothing unmasked pending means the request drops
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~mask_q) == ZEROS) |=> !irq);

  // R11: a request always traces back to an unmasked status bit
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(stat_q & ~mask_q)));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int NPIN = 32;
  localparam int AW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin_in = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NPIN-1:0] wdata = '0;
  logic [NPIN-1:0] rdata;
  logic            irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NPIN-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NPIN-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic stat_bit(input string tag, input int b, input logic exp);
    logic [NPIN-1:0] v;
    rd(5'h10, v);
    chk(tag, {31'd0, v[b]}, {31'd0, exp});
  endtask

  task automatic t_reset;
    logic [NPIN-1:0] v;
    rd(5'h00, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R1 mode", v, 32'h0);
    rd(5'h08, v); chk("R1 pol", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 both", v, 32'h0);
    rd(5'h10, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_regs;
    logic [NPIN-1:0] v;
    wr(5'h0C, 32'h0000_0004);
    rd(5'h0C, v); chk("R2 both readback", v, 32'h0000_0004);
    wr(5'h04, 32'h0000_0027);
    rd(5'h04, v); chk("R2 mode readback", v, 32'h0000_0027);
    wr(5'h08, 32'hFFFF_FFFD);
    rd(5'h08, v); chk("R2 pol readback", v, 32'hFFFF_FFFD);
    rd(5'h14, v); chk("R2 unmapped", v, 32'h0);
  endtask

  task automatic t_rise;
    pin_in[0] = 1'b1; settle(3);
    stat_bit("R3 rising sets", 0, 1'b1);
    wr(5'h10, 32'h0000_0001);
    stat_bit("R7 ack clears edge", 0, 1'b0);
    pin_in[0] = 1'b0; settle(4);
    stat_bit("R3 falling ignored", 0, 1'b0);
  endtask

  task automatic t_fall;
    pin_in[1] = 1'b1; settle(4);
    stat_bit("R4 rising ignored", 1, 1'b0);
    pin_in[1] = 1'b0; settle(3);
    stat_bit("R4 falling sets", 1, 1'b1);
    wr(5'h10, 32'h0);
    stat_bit("R7 write 0 keeps", 1, 1'b1);
    wr(5'h10, 32'h0000_0002);
    stat_bit("R7 ack clears", 1, 1'b0);
  endtask

  task automatic t_both;
    pin_in[2] = 1'b1; settle(3);
    stat_bit("R5 rise sets", 2, 1'b1);
    wr(5'h10, 32'h0000_0004);
    stat_bit("R5 cleared", 2, 1'b0);
    pin_in[2] = 1'b0; settle(3);
    stat_bit("R5 fall sets", 2, 1'b1);
    wr(5'h10, 32'h0000_0004);
  endtask

  task automatic t_level;
    pin_in[3] = 1'b1; settle(3);
    stat_bit("R6 level high sets", 3, 1'b1);
    wr(5'h10, 32'h0000_0008);
    stat_bit("R8 ack while active", 3, 1'b1);
    pin_in[3] = 1'b0; settle(3);
    stat_bit("R6 level held sticky", 3, 1'b1);
    wr(5'h10, 32'h0000_0008);
    stat_bit("R7 ack after release", 3, 1'b0);
    wr(5'h08, 32'hFFFF_FFED);
    settle(1);
    stat_bit("R6 level low sets", 4, 1'b1);
  endtask

  task automatic t_mask;
    pin_in[5] = 1'b1; settle(4);
    stat_bit("R10 status while masked", 5, 1'b1);
    chk("R10 masked irq low", {31'd0, irq}, 32'd0);
    wr(5'h00, 32'hFFFF_FFDF);
    chk("R11 irq registered", {31'd0, irq}, 32'd0);
    settle(1);
    chk("R10 irq after unmask", {31'd0, irq}, 32'd1);
    wr(5'h10, 32'h0000_0020);
    settle(1);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);
    pin_in[5] = 1'b0;
    wr(5'h00, 32'hFFFF_FFFF);
    settle(3);
  endtask

  task automatic t_collide;
    pin_in[2] = 1'b1; settle(3);
    stat_bit("R9 pre set", 2, 1'b1);
    pin_in[2] = 1'b0;
    settle(2);
    wr_en = 1'b1; addr = 5'h10; wdata = 32'h0000_0004;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    stat_bit("R9 set wins", 2, 1'b1);
    wr(5'h10, 32'h0000_0004);
    stat_bit("R9 later clear", 2, 1'b0);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule